// File: doc/BRIEF.md
# Vector Index Conflict Detector

This block compares every element of one vector of index values against the earlier elements of a second vector. For each element position it returns a bitmask that marks the earlier positions holding an equal value. A memory scheduler uses the result to find indices that would collide when a batch of loads or stores is issued at once. Software building a histogram in parallel uses it to merge updates to the same bin.

A request is a pulse on the start strobe, presented together with both source vectors and an active length. Only elements below that length take part. Every pairwise equality compare is made in a single combinational matrix. The result is captured in an output register, and a done pulse marks it valid. An optional input register stage adds one cycle of latency, which shortens the path into the compare matrix. The captured masks are held until the next request.

Top module: `vec_conflict_detect`

## Requirements
- R1: For an accepted request, bit j of element i's mask is 1 exactly when j < i, i < VL, j < VL and element i of source A equals element j of source B. Otherwise the bit is 0.
- R2: The masks are strictly triangular. Bit j of element i is 0 whenever j >= i, so element 0's mask is always zero, and so is the mask of an element with no earlier match.
- R3: Elements at position VL or above get an all-zero mask, and their values never set a bit in any other element's mask.
- R4: A VL value larger than NUM_ELEM acts as NUM_ELEM.
- R5: With VL = 0, every mask is zero and done is still pulsed.
- R6: done_o is high for exactly one cycle, LAT cycles after the cycle in which start_i was sampled high. LAT is 1 when PIPE_MODE is REG_OUT_ONLY (the default) and 2 when it is REG_IN_OUT.
- R7: mask_o keeps its value between requests. Source or VL changes without start_i leave it unchanged.
- R8: While rst_ni is low, mask_o is all zero and done_o is low.
- R9: When both sources carry the same vector, the output equals a self-conflict check: bit j of element i is set when j < i < VL and element j equals element i.
- R10: Element k of a source occupies bits [k*ELEM_W +: ELEM_W]. Element i's mask occupies mask_o bits [i*NUM_ELEM +: NUM_ELEM], and bit j of that field refers to position j.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe; sources and VL are sampled with it |
| vl_i | input | $clog2(NUM_ELEM+1) | Active vector length |
| src_a_i | input | NUM_ELEM*ELEM_W | Packed source A elements, compared at position i |
| src_b_i | input | NUM_ELEM*ELEM_W | Packed source B elements, compared at earlier positions j |
| mask_o | output | NUM_ELEM*NUM_ELEM | Packed per-element conflict masks |
| done_o | output | 1 | One-cycle pulse when mask_o holds a new result |

## Verification
The detector is first driven with the mixed-duplicate example vector, sweeping VL over all 16 codes. This shows that the length cut-off works, that lengths above the element count are clamped, and that the zero-length case still pulses done. An all-equal vector fills the whole lower triangle and nothing above it, which exposes any diagonal or upper-triangle leak. Several hundred generated vectors follow, with values drawn from a small alphabet so that matches are frequent. They alternate between identical sources and distinct sources, which tells a self-conflict path apart from a true A-against-B compare. A single planted pair pins down the field placement, and input changes without a strobe confirm that the result is held.

// File: rtl/vcd_pkg.sv
package vcd_pkg;
   // Pipeline variants of the detector
   typedef enum logic {
      REG_OUT_ONLY = 1'b0,
      REG_IN_OUT   = 1'b1
   } pipe_mode_e;

   localparam int unsigned VCD_MAX_ELEM = 32;
endpackage

// File: rtl/vcd_vl_gate.sv
module vcd_vl_gate #(
   parameter int unsigned NUM_ELEM = 8,
   parameter int unsigned VL_W     = $clog2(NUM_ELEM + 1)
) (
   input  logic [VL_W-1:0]     vl_i,
   output logic [NUM_ELEM-1:0] active_o
);
   // An element is active when its position lies below the length;
   // lengths above NUM_ELEM therefore saturate naturally.
   always_comb begin
      for (int i = 0; i < NUM_ELEM; i++) begin
         active_o[i] = (i < int'(vl_i));
      end
   end
endmodule

// File: rtl/vcd_cmp_matrix.sv
module vcd_cmp_matrix #(
   parameter int unsigned NUM_ELEM = 8,
   parameter int unsigned ELEM_W   = 16
) (
   input  logic [NUM_ELEM*ELEM_W-1:0]   src_a_i,
   input  logic [NUM_ELEM*ELEM_W-1:0]   src_b_i,
   input  logic [NUM_ELEM-1:0]          active_i,
   output logic [NUM_ELEM*NUM_ELEM-1:0] mask_o
);
   // Lower triangle holds comparators; diagonal and above are tied off.
   for (genvar gi = 0; gi < NUM_ELEM; gi++) begin : g_row
      for (genvar gj = 0; gj < NUM_ELEM; gj++) begin : g_col
         if (gj < gi) begin : g_cmp
            assign mask_o[gi*NUM_ELEM + gj] =
               active_i[gi] & active_i[gj] &
               (src_a_i[gi*ELEM_W +: ELEM_W] == src_b_i[gj*ELEM_W +: ELEM_W]);
         end else begin : g_zero
            assign mask_o[gi*NUM_ELEM + gj] = 1'b0;
         end
      end
   end
endmodule

// File: rtl/vec_conflict_detect.sv
module vec_conflict_detect
   import vcd_pkg::*;
#(
   parameter int unsigned NUM_ELEM  = 8,
   parameter int unsigned ELEM_W    = 16,
   parameter pipe_mode_e  PIPE_MODE = REG_OUT_ONLY,
   localparam int unsigned VL_W     = $clog2(NUM_ELEM + 1),
   localparam int unsigned VEC_W    = NUM_ELEM * ELEM_W,
   localparam int unsigned MASK_W   = NUM_ELEM * NUM_ELEM
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [VL_W-1:0]   vl_i,
   input  logic [VEC_W-1:0]  src_a_i,
   input  logic [VEC_W-1:0]  src_b_i,
   output logic [MASK_W-1:0] mask_o,
   output logic              done_o
);
   localparam int unsigned LAT = (PIPE_MODE == REG_IN_OUT) ? 2 : 1;

   // Diagonal-and-above positions, used by the checks below
   function automatic logic [MASK_W-1:0] upper_pattern();
      logic [MASK_W-1:0] p;
      p = '0;
      for (int i = 0; i < NUM_ELEM; i++)
         for (int j = i; j < NUM_ELEM; j++)
            p[i*NUM_ELEM + j] = 1'b1;
      return p;
   endfunction
   localparam logic [MASK_W-1:0] UPPER = upper_pattern();

   // Elaboration-time parameter checks
   if (NUM_ELEM < 2 || NUM_ELEM > VCD_MAX_ELEM) begin : g_bad_elem
      $error("vec_conflict_detect: NUM_ELEM out of range");
   end
   if (ELEM_W < 1) begin : g_bad_width
      $error("vec_conflict_detect: ELEM_W must be positive");
   end

   logic [VEC_W-1:0]    s_a, s_b;
   logic [VL_W-1:0]     s_vl;
   logic                s_go;
   logic [NUM_ELEM-1:0] active;
   logic [MASK_W-1:0]   matrix;

   // Optional input stage selected by PIPE_MODE
   if (PIPE_MODE == REG_IN_OUT) begin : g_in_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            s_a  <= '0;
            s_b  <= '0;
            s_vl <= '0;
            s_go <= 1'b0;
         end else begin
            s_go <= start_i;
            if (start_i) begin
               s_a  <= src_a_i;
               s_b  <= src_b_i;
               s_vl <= vl_i;
            end
         end
      end
   end else begin : g_in_pass
      assign s_a  = src_a_i;
      assign s_b  = src_b_i;
      assign s_vl = vl_i;
      assign s_go = start_i;
   end

   vcd_vl_gate #(
      .NUM_ELEM (NUM_ELEM),
      .VL_W     (VL_W)
   ) u_gate (
      .vl_i     (s_vl),
      .active_o (active)
   );

   vcd_cmp_matrix #(
      .NUM_ELEM (NUM_ELEM),
      .ELEM_W   (ELEM_W)
   ) u_matrix (
      .src_a_i  (s_a),
      .src_b_i  (s_b),
      .active_i (active),
      .mask_o   (matrix)
   );

   // Output register: capture on request, hold otherwise
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mask_o <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= s_go;
         if (s_go) mask_o <= matrix;
      end
   end

   // R2
   triangular_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask_o & UPPER) == '0);

   // R6
   done_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> $past(start_i, LAT));

   // R7
   mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_o |-> $stable(mask_o));

   // R5
   zero_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && $past(vl_i, LAT) == '0) |-> (mask_o == '0));
endmodule

// File: tb/vec_conflict_detect_test.sv
module vec_conflict_detect_test;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 8;
   localparam int W  = 16;
   localparam int VW = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [VW-1:0]   vl = '0;
   logic [N*W-1:0]  src_a = '0, src_b = '0;
   logic [N*N-1:0]  mask;
   logic            done;

   int checks = 0;
   int fails  = 0;
   logic [31:0] rng = 32'h1234_5678;

   always #(CLK_PERIOD/2) clk = ~clk;

   vec_conflict_detect uut (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .start_i (start),
      .vl_i    (vl),
      .src_a_i (src_a),
      .src_b_i (src_b),
      .mask_o  (mask),
      .done_o  (done)
   );

   task automatic check(input string req, input logic [N*N-1:0] act, input logic [N*N-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [N*N-1:0] ref_mask(input logic [N*W-1:0] a,
                                               input logic [N*W-1:0] b, input int len);
      logic [N*N-1:0] m;
      int lim;
      m = '0;
      lim = (len > N) ? N : len;
      for (int i = 0; i < lim; i++)
         for (int j = 0; j < i; j++)
            if (a[i*W +: W] == b[j*W +: W]) m[i*N + j] = 1'b1;
      return m;
   endfunction

   function automatic logic [31:0] next_rng(input logic [31:0] s);
      logic [31:0] x;
      x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   // Issue one request and check result, pulse width and hold (R1, R6, R7)
   task automatic run(input string req, input logic [N*W-1:0] a,
                      input logic [N*W-1:0] b, input int len);
      logic [N*N-1:0] exp;
      exp = ref_mask(a, b, len);
      @(negedge clk);
      src_a = a; src_b = b; vl = VW'(len); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check({req, " R6 done"}, {{(N*N-1){1'b0}}, done}, 1);
      check(req, mask, exp);
      src_a = ~a;
      vl = VW'(N);
      @(negedge clk);
      check("R6 done one cycle", {{(N*N-1){1'b0}}, done}, 0);
      check("R7 hold", mask, exp);
   endtask

   function automatic logic [N*W-1:0] pack(input int v0, v1, v2, v3, v4, v5, v6, v7);
      return {W'(v7), W'(v6), W'(v5), W'(v4), W'(v3), W'(v2), W'(v1), W'(v0)};
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [N*W-1:0] ex, a, b;
      logic [N*N-1:0] e;
      #(CLK_PERIOD * 3 + 1);
      // R8 reset state
      check("R8 mask in reset", mask, '0);
      check("R8 done in reset", {{(N*N-1){1'b0}}, done}, 0);
      @(negedge clk);
      rst_n = 1'b1;

      ex = pack(100, 100, 3, 100, 5, 100, 100, 3);
      // R1 R9 example: element 7 mask = 0x04, element 4 zero
      run("R9 example self", ex, ex, 8);
      check("R1 element7", {{(N*N-N){1'b0}}, mask[7*N +: N]}, 8'h04);
      check("R2 element4 zero", {{(N*N-N){1'b0}}, mask[4*N +: N]}, 0);

      // R3 R4 R5 VL sweep over every code
      for (int v = 0; v < 16; v++) begin
         if (v == 0) run("R5 vl zero", ex, ex, v);
         else if (v > N) run("R4 vl clamp", ex, ex, v);
         else run("R3 vl cut", ex, ex, v);
      end

      // R2 all-equal fills lower triangle only
      a = pack(7, 7, 7, 7, 7, 7, 7, 7);
      run("R2 all equal", a, a, 8);
      e = '0;
      for (int i = 0; i < N; i++) e[i*N +: N] = N'((1 << i) - 1);
      check("R2 triangle", mask, e);

      // R10 planted pair: only element 6 matches element 1 of B
      a = pack(1, 2, 3, 4, 5, 6, 2, 8);
      b = pack(11, 2, 13, 14, 15, 16, 17, 18);
      run("R10 packing", a, b, 8);
      e = '0; e[6*N + 1] = 1'b1;
      check("R10 bit position", mask, e);

      // R3 element beyond VL is no partner: match only in hidden position
      a = pack(9, 1, 2, 3, 4, 5, 6, 9);
      run("R3 beyond vl", a, a, 7);
      check("R3 no hidden match", mask, '0);

      // R1 R9 generated sweep, small alphabet
      for (int t = 0; t < 400; t++) begin
         for (int k = 0; k < N; k++) begin
            rng = next_rng(rng); a[k*W +: W] = W'(rng[3:0] % 4);
            rng = next_rng(rng); b[k*W +: W] = W'(rng[7:4] % 4);
         end
         rng = next_rng(rng);
         if (t % 2 == 0) run("R9 self random", a, a, int'(rng[11:8]) % (N + 1));
         else run("R1 cross random", a, b, int'(rng[11:8]) % (N + 1));
      end

      // R7 input churn without start
      e = mask;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         rng = next_rng(rng);
         src_a = {4{rng}}; src_b = {4{~rng}}; vl = VW'(k);
      end
      @(negedge clk);
      check("R7 no start", mask, e);
      check("R7 no done", {{(N*N-1){1'b0}}, done}, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule